// File: doc/BRIEF.md
# Two-Level Page Translation Cache with I/O Filtering

This block caches virtual-to-physical page translations in front of a slow external translation engine. Every access is looked up, even with address translation switched off. A request carries a virtual page number and a translation-enable bit. The response returns a physical page number and an I/O attribute that marks memory-mapped device pages.

The first level is a direct-mapped array that is probed in the accept cycle. The second level is a small fully associative array that is searched on the next cycle. If both levels miss and translation is enabled, the block asks the external walker port for the translation and waits for its answer. If translation is disabled, a miss is settled locally with an identity mapping. A resolved translation always goes into the associative level. It goes into the direct-mapped level only when it is not an I/O page, so device mappings never take slots in the fast array. One input invalidates both levels at once.

Top module: `xlat_tlb2_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and walk_req_valid is 0.
- R2: A request that hits the primary level gives rsp_valid exactly one cycle after the accepting edge, and req_ready stays 1.
- R3: The primary level is indexed by vpn[5:0] and tagged by the remaining vpn bits together with the translation-enable bit. A later fill of a page with the same index replaces the earlier one in the primary level.
- R4: A request that misses the primary level and hits the secondary level gives rsp_valid two cycles after the accepting edge.
- R5: With translation enabled and both levels missing, walk_req_valid rises one cycle after the secondary search. walk_req_vpn holds the request's page, and both stay stable until walk_rsp_valid. The response follows one cycle after walk_rsp_valid and carries the walker's page number and I/O flag.
- R6: A walk result is always written into the secondary level. It is written into the primary level only when its I/O flag is 0, so a repeated I/O page answers in two cycles and a repeated memory page in one.
- R7: With translation disabled, a miss starts no walk. It returns ppn = vpn, with the I/O flag set when the page is at or above IO_BASE_PPN (0xF0000 by default), two cycles after acceptance. It fills under the same rules as R6.
- R8: A translation installed with translation enabled never answers a request with translation disabled for the same vpn, and the reverse also holds.
- R9: A secondary fill uses the lowest-numbered invalid way when one exists. Otherwise it evicts ways in round-robin order, starting at way 0 after reset or invalidation.
- R10: inval_all clears every entry of both levels at the next edge, and it takes priority over a fill in the same cycle. The response to that fill is still delivered.
- R11: req_ready is 0 from the edge that accepts a missing request until the edge that produces its response.
- R12: A walk_rsp_valid pulse while no walk is pending produces no response and installs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vpn | input | VPN_W | Virtual page number |
| req_xlate_en | input | 1 | 1 = translate, 0 = identity-map |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ppn | output | PPN_W | Physical page number |
| rsp_io | output | 1 | Page is memory-mapped I/O |
| walk_req_valid | output | 1 | Walk requested, held until answered |
| walk_req_vpn | output | VPN_W | Page to be walked |
| walk_rsp_valid | input | 1 | Walker answer strobe |
| walk_rsp_ppn | input | PPN_W | Walked physical page number |
| walk_rsp_io | input | 1 | Walked page is I/O |
| inval_all | input | 1 | Invalidate both levels |

## Verification
A corrupted valid bit, tag or replacement pointer does not show up as a wrong value right away. It shows up as a wrong latency on the next request to the affected page. A stale hit answers in one or two cycles where a walk of five was due. A lost entry starts an unexpected walk. For this reason every check compares latency as well as data, and each scenario revisits its pages after the state-changing event. A wrong I/O-filter decision becomes visible on the second request to an I/O page, which answers in one cycle instead of two.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_SEC  = 2'd1,
      XS_WALK = 2'd2
   } xlat_state_e;
endpackage

// File: rtl/xlat_l1_dm.sv
// Direct-mapped first level; never holds I/O pages.
module xlat_l1_dm #(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PPN_W = 20,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inval,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic             lk_mode,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic             wr_mode,
   input  logic [PPN_W-1:0] wr_ppn
);
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam int unsigned TAG_W = VPN_W - IDX_W + 1;

   logic [DEPTH-1:0] vld_q;
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [PPN_W-1:0] ppn_q [DEPTH];

   logic [IDX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0] lk_tag, wr_tag;

   assign lk_idx = lk_vpn[IDX_W-1:0];
   assign wr_idx = wr_vpn[IDX_W-1:0];
   assign lk_tag = {lk_mode, lk_vpn[VPN_W-1:IDX_W]};
   assign wr_tag = {wr_mode, wr_vpn[VPN_W-1:IDX_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= '0;
      else if (inval) vld_q <= '0;
      else if (wr_en) vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         ppn_q[wr_idx] <= wr_ppn;
      end
   end

   assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_ppn = ppn_q[lk_idx];
endmodule

// File: rtl/xlat_l2_fa.sv
// Fully associative second level with invalid-first, round-robin fill.
module xlat_l2_fa #(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PPN_W = 20,
   parameter int unsigned WAYS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inval,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic             lk_mode,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output logic             lk_io,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic             wr_mode,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic             wr_io
);
   localparam int unsigned WAY_W = $clog2(WAYS);

   logic [WAYS-1:0]  vld_vec;
   logic [WAYS-1:0]  hit_vec;
   logic [WAYS-1:0]  io_vec;
   logic [PPN_W-1:0] ppn_vec [WAYS];
   logic [WAY_W-1:0] rr_q;
   logic [WAY_W-1:0] victim;
   logic             have_free;

   always_comb begin
      victim    = rr_q;
      have_free = 1'b0;
      for (int i = 0; i < WAYS; i++) begin
         if (!vld_vec[i] && !have_free) begin
            victim    = WAY_W'(i);
            have_free = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rr_q <= '0;
      else if (inval)              rr_q <= '0;
      else if (wr_en && !have_free) rr_q <= rr_q + 1'b1;
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic             v_q;
      logic             mode_q;
      logic             io_q;
      logic [VPN_W-1:0] vpn_q;
      logic [PPN_W-1:0] ppn_q;
      logic             sel;

      assign sel = wr_en && (victim == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     v_q <= 1'b0;
         else if (inval) v_q <= 1'b0;
         else if (sel)   v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            vpn_q  <= wr_vpn;
            mode_q <= wr_mode;
            ppn_q  <= wr_ppn;
            io_q   <= wr_io;
         end
      end

      assign vld_vec[w] = v_q;
      assign hit_vec[w] = v_q && (vpn_q == lk_vpn) && (mode_q == lk_mode);
      assign io_vec[w]  = io_q;
      assign ppn_vec[w] = ppn_q;
   end

   always_comb begin
      lk_ppn = '0;
      lk_io  = 1'b0;
      for (int i = 0; i < WAYS; i++) begin
         if (hit_vec[i]) begin
            lk_ppn = lk_ppn | ppn_vec[i];
            lk_io  = lk_io | io_vec[i];
         end
      end
   end

   assign lk_hit = |hit_vec;
endmodule

// File: rtl/xlat_ctrl.sv
// Sequencer: primary probe, secondary search, walk or identity resolve.
module xlat_ctrl
   import xlat_pkg::*;
#(
   parameter int unsigned VPN_W       = 20,
   parameter int unsigned PPN_W       = 20,
   parameter int unsigned IO_BASE_PPN = 'hF0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic             req_mode,
   input  logic             pri_hit,
   input  logic [PPN_W-1:0] pri_ppn,
   input  logic             sec_hit,
   input  logic [PPN_W-1:0] sec_ppn,
   input  logic             sec_io,
   output logic             walk_req_valid,
   output logic [VPN_W-1:0] walk_req_vpn,
   input  logic             walk_rsp_valid,
   input  logic [PPN_W-1:0] walk_rsp_ppn,
   input  logic             walk_rsp_io,
   output logic [VPN_W-1:0] cur_vpn,
   output logic             cur_mode,
   output logic             fill_sec,
   output logic             fill_pri,
   output logic [PPN_W-1:0] fill_ppn,
   output logic             fill_io,
   output logic             rsp_valid,
   output logic [PPN_W-1:0] rsp_ppn,
   output logic             rsp_io
);
   xlat_state_e      state_q, state_d;
   logic             accept;
   logic             pri_done, sec_done, ident_done, walk_done, fill_any;
   logic [PPN_W-1:0] ident_ppn;
   logic             ident_io;

   assign req_ready  = (state_q == XS_IDLE);
   assign accept     = req_valid && req_ready;
   assign pri_done   = accept && pri_hit;
   assign sec_done   = (state_q == XS_SEC) && sec_hit;
   assign ident_done = (state_q == XS_SEC) && !sec_hit && !cur_mode;
   assign walk_done  = (state_q == XS_WALK) && walk_rsp_valid;
   assign fill_any   = ident_done || walk_done;

   assign ident_ppn = PPN_W'(cur_vpn);
   assign ident_io  = (ident_ppn >= PPN_W'(IO_BASE_PPN));

   assign fill_ppn = walk_done ? walk_rsp_ppn : ident_ppn;
   assign fill_io  = walk_done ? walk_rsp_io  : ident_io;
   assign fill_sec = fill_any;
   assign fill_pri = fill_any && !fill_io;

   assign walk_req_valid = (state_q == XS_WALK);
   assign walk_req_vpn   = cur_vpn;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         XS_IDLE: if (accept && !pri_hit) state_d = XS_SEC;
         XS_SEC:  state_d = (!sec_hit && cur_mode) ? XS_WALK : XS_IDLE;
         XS_WALK: if (walk_rsp_valid) state_d = XS_IDLE;
         default: state_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= XS_IDLE;
         cur_vpn   <= '0;
         cur_mode  <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_ppn   <= '0;
         rsp_io    <= 1'b0;
      end else begin
         state_q   <= state_d;
         rsp_valid <= pri_done || sec_done || fill_any;
         if (accept) begin
            cur_vpn  <= req_vpn;
            cur_mode <= req_mode;
         end
         if (pri_done) begin
            rsp_ppn <= pri_ppn;
            rsp_io  <= 1'b0;
         end else if (sec_done) begin
            rsp_ppn <= sec_ppn;
            rsp_io  <= sec_io;
         end else if (fill_any) begin
            rsp_ppn <= fill_ppn;
            rsp_io  <= fill_io;
         end
      end
   end
endmodule

// File: rtl/xlat_tlb2_top.sv
module xlat_tlb2_top #(
   parameter int unsigned VPN_W       = 20,
   parameter int unsigned PPN_W       = 20,
   parameter int unsigned PRI_IDX_W   = 6,
   parameter int unsigned SEC_WAYS    = 4,
   parameter int unsigned IO_BASE_PPN = 'hF0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic             req_xlate_en,
   output logic             rsp_valid,
   output logic [PPN_W-1:0] rsp_ppn,
   output logic             rsp_io,
   output logic             walk_req_valid,
   output logic [VPN_W-1:0] walk_req_vpn,
   input  logic             walk_rsp_valid,
   input  logic [PPN_W-1:0] walk_rsp_ppn,
   input  logic             walk_rsp_io,
   input  logic             inval_all
);
   if (VPN_W <= PRI_IDX_W) begin : g_bad_idx
      $error("xlat_tlb2_top: VPN_W must exceed PRI_IDX_W");
   end
   if (PPN_W < VPN_W) begin : g_bad_ppn
      $error("xlat_tlb2_top: identity map needs PPN_W >= VPN_W");
   end
   if (SEC_WAYS < 2 || (SEC_WAYS & (SEC_WAYS - 1)) != 0) begin : g_bad_ways
      $error("xlat_tlb2_top: SEC_WAYS must be a power of two >= 2");
   end

   logic             pri_hit, sec_hit, sec_io;
   logic [PPN_W-1:0] pri_ppn, sec_ppn;
   logic [VPN_W-1:0] cur_vpn;
   logic             cur_mode;
   logic             fill_sec, fill_pri, fill_io;
   logic [PPN_W-1:0] fill_ppn;

   xlat_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IO_BASE_PPN(IO_BASE_PPN)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vpn(req_vpn), .req_mode(req_xlate_en),
      .pri_hit(pri_hit), .pri_ppn(pri_ppn),
      .sec_hit(sec_hit), .sec_ppn(sec_ppn), .sec_io(sec_io),
      .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
      .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn),
      .walk_rsp_io(walk_rsp_io),
      .cur_vpn(cur_vpn), .cur_mode(cur_mode),
      .fill_sec(fill_sec), .fill_pri(fill_pri),
      .fill_ppn(fill_ppn), .fill_io(fill_io),
      .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_io(rsp_io)
   );

   xlat_l1_dm #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(PRI_IDX_W)) u_pri (
      .clk(clk), .rst_n(rst_n), .inval(inval_all),
      .lk_vpn(req_vpn), .lk_mode(req_xlate_en),
      .lk_hit(pri_hit), .lk_ppn(pri_ppn),
      .wr_en(fill_pri), .wr_vpn(cur_vpn), .wr_mode(cur_mode), .wr_ppn(fill_ppn)
   );

   xlat_l2_fa #(.VPN_W(VPN_W), .PPN_W(PPN_W), .WAYS(SEC_WAYS)) u_sec (
      .clk(clk), .rst_n(rst_n), .inval(inval_all),
      .lk_vpn(cur_vpn), .lk_mode(cur_mode),
      .lk_hit(sec_hit), .lk_ppn(sec_ppn), .lk_io(sec_io),
      .wr_en(fill_sec), .wr_vpn(cur_vpn), .wr_mode(cur_mode),
      .wr_ppn(fill_ppn), .wr_io(fill_io)
   );
endmodule

// File: rtl/xlat_tlb2_chk.sv
module xlat_tlb2_chk #(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic [PPN_W-1:0] rsp_ppn,
   input logic             rsp_io,
   input logic             walk_req_valid,
   input logic [VPN_W-1:0] walk_req_vpn,
   input logic             walk_rsp_valid,
   input logic [PPN_W-1:0] walk_rsp_ppn,
   input logic             walk_rsp_io,
   input logic             inval_all
);
   p_hit_or_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_valid || !req_ready));

   p_walk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn)));

   p_walk_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req_valid && walk_rsp_valid) |=>
         (rsp_valid && rsp_ppn == $past(walk_rsp_ppn) && rsp_io == $past(walk_rsp_io)));

   p_io_not_primary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_io) |-> $past(!req_ready));

   p_inval_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inval_all) && req_valid && req_ready) |=> !rsp_valid);

   p_busy_in_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid |-> !req_ready);
endmodule

bind xlat_tlb2_top xlat_tlb2_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_io(rsp_io),
   .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
   .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn),
   .walk_rsp_io(walk_rsp_io), .inval_all(inval_all)
);

// File: tb/xlat_tlb2_top_tb_top.sv
`timescale 1ns/1ps
module xlat_tlb2_top_tb_top;
   localparam int VW = 20;
   localparam int PW = 20;
   localparam int WALK_LAT = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [VW-1:0] req_vpn = '0;
   logic          req_xlate_en = 1'b0;
   logic          rsp_valid;
   logic [PW-1:0] rsp_ppn;
   logic          rsp_io;
   logic          walk_req_valid;
   logic [VW-1:0] walk_req_vpn;
   logic          walk_rsp_valid = 1'b0;
   logic [PW-1:0] walk_rsp_ppn = '0;
   logic          walk_rsp_io = 1'b0;
   logic          inval_all = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int walks = 0;
   bit spur_go = 0;
   logic [VW-1:0] spur_vpn = '0;
   bit inval_on_rsp = 0;
   bit walk_vpn_bad = 0;

   always #4 clk = ~clk;

   xlat_tlb2_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vpn(req_vpn), .req_xlate_en(req_xlate_en),
      .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_io(rsp_io),
      .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
      .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn),
      .walk_rsp_io(walk_rsp_io), .inval_all(inval_all)
   );

   function automatic logic [PW-1:0] ppn_of(input logic [VW-1:0] v);
      return PW'(v + 20'h12345);
   endfunction
   function automatic logic io_of(input logic [VW-1:0] v);
      return v[VW-1:VW-4] == 4'hC;
   endfunction

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Walker model: answers three cycles after the request appears.
   initial begin
      int  wcnt = 0;
      bit  w_inval = 0;
      logic [VW-1:0] wvpn = '0;
      forever begin
         @(negedge clk);
         if (walk_rsp_valid) begin
            walk_rsp_valid = 1'b0;
            if (w_inval) begin inval_all = 1'b0; w_inval = 0; end
         end else if (spur_go) begin
            walk_rsp_valid = 1'b1;
            walk_rsp_ppn   = ppn_of(spur_vpn);
            walk_rsp_io    = 1'b0;
            spur_go        = 0;
         end else if (walk_req_valid) begin
            if (wcnt == 0) wvpn = walk_req_vpn;
            else if (walk_req_vpn != wvpn) walk_vpn_bad = 1;
            wcnt++;
            if (wcnt == 3) begin
               walk_rsp_valid = 1'b1;
               walk_rsp_ppn   = ppn_of(wvpn);
               walk_rsp_io    = io_of(wvpn);
               walks++;
               wcnt = 0;
               if (inval_on_rsp) begin
                  inval_all = 1'b1; w_inval = 1; inval_on_rsp = 0;
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   task automatic do_req(input logic [VW-1:0] v, input bit m, output int lat,
                         output logic [PW-1:0] p, output logic io, output bit busy_ok);
      @(negedge clk);
      req_vpn = v; req_xlate_en = m; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1; busy_ok = 1;
      while (!rsp_valid && lat < 60) begin
         if (req_ready) busy_ok = 0;
         @(negedge clk);
         lat++;
      end
      p = rsp_ppn; io = rsp_io;
      if (!req_ready) busy_ok = 0;
   endtask

   task automatic expect_req(input logic [VW-1:0] v, input bit m, input int elat,
                             input logic [PW-1:0] eppn, input logic eio, input string tag);
      int lat; logic [PW-1:0] p; logic io; bit bok;
      do_req(v, m, lat, p, io, bok);
      chk(lat == elat, {tag, " latency"}, lat, elat);
      chk(p == eppn,   {tag, " ppn"}, p, eppn);
      chk(io == eio,   {tag, " io"}, io, eio);
      chk(bok,         {tag, " R11 ready while busy"}, !bok, 0);
   endtask

   task automatic flush();
      @(negedge clk); inval_all = 1'b1;
      @(negedge clk); inval_all = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready == 1'b1,      "R1 req_ready", req_ready, 1);
      chk(rsp_valid == 1'b0,      "R1 rsp_valid", rsp_valid, 0);
      chk(walk_req_valid == 1'b0, "R1 walk_req_valid", walk_req_valid, 0);
   endtask

   task automatic t_primary();
      flush();
      expect_req(20'h00123, 1, WALK_LAT, ppn_of(20'h00123), 0, "R5 first walk");
      expect_req(20'h00123, 1, 1, ppn_of(20'h00123), 0, "R2 primary hit");
      expect_req(20'h3A7C5, 1, WALK_LAT, ppn_of(20'h3A7C5), 0, "R5 second walk");
      expect_req(20'h3A7C5, 1, 1, ppn_of(20'h3A7C5), 0, "R2 primary hit 2");
   endtask

   task automatic t_alias();
      flush();
      expect_req(20'h00041, 1, WALK_LAT, ppn_of(20'h00041), 0, "R3 fill X");
      expect_req(20'h00081, 1, WALK_LAT, ppn_of(20'h00081), 0, "R3 fill Y same index");
      expect_req(20'h00041, 1, 2, ppn_of(20'h00041), 0, "R4 secondary hit X");
      expect_req(20'h00081, 1, 1, ppn_of(20'h00081), 0, "R3 primary holds Y");
   endtask

   task automatic t_walk_io();
      int w0;
      flush();
      walk_vpn_bad = 0;
      expect_req(20'hC1234, 1, WALK_LAT, ppn_of(20'hC1234), 1, "R5 io walk");
      chk(!walk_vpn_bad, "R5 walk_req_vpn stable", walk_vpn_bad, 0);
      w0 = walks;
      expect_req(20'hC1234, 1, 2, ppn_of(20'hC1234), 1, "R6 io page secondary only");
      chk(walks == w0, "R6 no rewalk", walks, w0);
   endtask

   task automatic t_ident();
      int w0;
      flush();
      w0 = walks;
      expect_req(20'h01234, 0, 2, 20'h01234, 0, "R7 identity miss");
      expect_req(20'h01234, 0, 1, 20'h01234, 0, "R7 identity primary hit");
      expect_req(20'hF0010, 0, 2, 20'hF0010, 1, "R7 identity io");
      expect_req(20'hF0010, 0, 2, 20'hF0010, 1, "R7 identity io not in primary");
      chk(walks == w0, "R7 no walk when disabled", walks, w0);
   endtask

   task automatic t_mode_tag();
      flush();
      expect_req(20'h05555, 0, 2, 20'h05555, 0, "R8 identity entry");
      expect_req(20'h05555, 1, WALK_LAT, ppn_of(20'h05555), 0, "R8 translated walks");
      expect_req(20'h05555, 0, 2, 20'h05555, 0, "R8 identity from secondary");
      expect_req(20'h05555, 1, 1, ppn_of(20'h05555), 0, "R8 translated primary");
   endtask

   task automatic t_rr();
      flush();
      for (int i = 1; i <= 5; i++) begin
         logic [VW-1:0] v;
         v = 20'hC0000 + VW'(i);
         expect_req(v, 1, WALK_LAT, ppn_of(v), 1, "R9 fill");
      end
      expect_req(20'hC0002, 1, 2, ppn_of(20'hC0002), 1, "R9 way1 kept");
      expect_req(20'hC0001, 1, WALK_LAT, ppn_of(20'hC0001), 1, "R9 way0 evicted");
      expect_req(20'hC0003, 1, 2, ppn_of(20'hC0003), 1, "R9 way2 kept");
      expect_req(20'hC0002, 1, WALK_LAT, ppn_of(20'hC0002), 1, "R9 way1 evicted next");
   endtask

   task automatic t_inval();
      flush();
      expect_req(20'h00777, 1, WALK_LAT, ppn_of(20'h00777), 0, "R10 fill");
      expect_req(20'h00777, 1, 1, ppn_of(20'h00777), 0, "R10 primary before");
      flush();
      expect_req(20'h00777, 1, WALK_LAT, ppn_of(20'h00777), 0, "R10 cleared");
      inval_on_rsp = 1;
      expect_req(20'h00999, 1, WALK_LAT, ppn_of(20'h00999), 0, "R10 rsp with inval");
      expect_req(20'h00999, 1, WALK_LAT, ppn_of(20'h00999), 0, "R10 inval beats fill");
   endtask

   task automatic t_spur();
      flush();
      spur_vpn = 20'h00ABC;
      spur_go = 1;
      @(negedge clk);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R12 no response", rsp_valid, 0);
      expect_req(20'h00ABC, 1, WALK_LAT, ppn_of(20'h00ABC), 0, "R12 nothing installed");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_primary();
      t_alias();
      t_walk_io();
      t_ident();
      t_mode_tag();
      t_rr();
      t_inval();
      t_spur();
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end
endmodule